// File: doc/BRIEF.md
# Mode-Gated Indexed Configuration Port

This block sits on a simple host register bus and exposes three byte-wide ports. The first is a slave control register. It holds a clock-stop request, a soft reset and a configuration-mode enable. The second is an index port. The third is a data port. Through the data port the host reaches a bank of general configuration bytes at the byte selected by the index port. The bank holds settings for the bridge interrupt, bridge enable, bus-master channel, serial-port interrupt, serial-port base and host bus timer.

The bank is reachable only while configuration mode is set. Host software follows a fixed sequence: save the control value, set the mode bit, write the index, access the data port, then write the saved control value back. The soft reset bit clears the bank and holds it clear. It is also driven out as a reset for downstream logic. The clock-stop output samples the clock-control bit only while soft reset is held, so clocks can only be gated or ungated under reset.

Top module: `cfg_port`

## Requirements
- R1: After rst_ni is released, the control register reads 0x00 and the index reads 0x00. All configuration bytes are zero, clk_stop_o and core_rst_o are 0, and ser_base_o is 0x03F8.
- R2: Port select 0 is the control register. Bit 0 is clock control, bit 1 is soft reset and bit 2 is configuration mode. A write stores bits 2:0, and bits 7:3 always read zero. Port select 3 reads zero and ignores writes.
- R3: A write to port select 1 stores the full 8-bit index, whatever the mode. Reading port select 1 returns the stored index.
- R4: With configuration mode set and soft reset clear, a write to port select 2 updates the configuration byte at the current index on the next clock edge. A read of port select 2 returns that byte.
- R5: With configuration mode clear, a write to port select 2 changes no configuration byte, and a read of port select 2 returns 0xFF.
- R6: Indices 6 to 255 are unimplemented. Writes to them are discarded, and reads from them return 0x00 while configuration mode is set.
- R7: Reserved bits in the configuration bytes always read as zero. The implemented bits are 0x1F at index 0, 0x01 at index 1, 0x1F at index 2, 0x1F at index 3, 0x07 at index 4 and 0xFF at index 5.
- R8: While the soft reset bit is set, core_rst_o is 1 and every configuration byte is cleared and held at zero, and data-port writes are discarded. Once the bit is cleared, the bytes accept writes again.
- R9: On each clock edge where the soft reset bit is set, clk_stop_o takes the value of the clock-control bit. On every other edge it holds its value.
- R10: Indices 0 and 3 are the bridge and serial interrupt bytes. In each, bit 0 is active-low polarity, bit 1 is pulse mode and bits 4:2 are the line number. Index 1 bit 0 is the bridge enable. Index 2 bits 2:0 are the bus-master channel and bits 4:3 are the burst count. Index 4 bit 0 is the serial enable and bits 2:1 are the base select. Index 5 is the timer load value. These fields drive the matching outputs directly.
- R11: The serial base select maps to ser_base_o as follows: 0 gives 0x03F8, 1 gives 0x02F8, 2 gives 0x03E8 and 3 gives 0x02E8.
- R12: Writing a saved control value back after an access leaves every configuration byte and field output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| port_i | input | 2 | Port select: 0 control, 1 index, 2 data, 3 none |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data of the selected port |
| clk_stop_o | output | 1 | Clock-stop request |
| core_rst_o | output | 1 | Downstream soft reset |
| br_irq_low_o | output | 1 | Bridge interrupt active-low |
| br_irq_pulse_o | output | 1 | Bridge interrupt pulse mode |
| br_irq_line_o | output | 3 | Bridge interrupt line |
| br_en_o | output | 1 | Bridge enable |
| dma_chan_o | output | 3 | Bus-master channel |
| dma_burst_o | output | 2 | Bus-master burst count |
| ser_irq_low_o | output | 1 | Serial interrupt active-low |
| ser_irq_pulse_o | output | 1 | Serial interrupt pulse mode |
| ser_irq_line_o | output | 3 | Serial interrupt line |
| ser_en_o | output | 1 | Serial port enable |
| ser_base_o | output | 16 | Decoded serial I/O base |
| timer_load_o | output | 8 | Host bus timer load value |

## Verification
Directed passes write every implemented index with all-ones data. This separates the stored bits from the reserved bits, and a pass over all four base selects separates the address decodes. Data-port writes are issued with the mode clear, with soft reset held and at an index past the bank. Each of these must leave the readback unchanged, which distinguishes the mode gate, the reset hold and the range check. Clock-control changes are made both with and without soft reset, to show that clk_stop_o moves only under reset. A long run of pseudo-random port writes then tests sequences that no directed pattern covers.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW         = 8;
  localparam int IDX_W      = 8;
  localparam int NUM_CFG    = 6;
  localparam int IRQ_LINE_W = 3;
  localparam int DMA_W      = 3;
  localparam int BURST_W    = 2;
  localparam int BASE_W     = 16;

  typedef enum logic [1:0] {
    PORT_CTL  = 2'd0,
    PORT_IDX  = 2'd1,
    PORT_DATA = 2'd2,
    PORT_NONE = 2'd3
  } port_sel_e;

  localparam int CTL_CLK  = 0;
  localparam int CTL_SRST = 1;
  localparam int CTL_MODE = 2;
  localparam int CTL_W    = 3;

  localparam int IX_BR_IRQ  = 0;
  localparam int IX_BR_CTL  = 1;
  localparam int IX_DMA     = 2;
  localparam int IX_SER_IRQ = 3;
  localparam int IX_SER_CTL = 4;
  localparam int IX_TIMER   = 5;

  typedef struct packed {
    logic [IRQ_LINE_W-1:0] line;
    logic                  pulse;
    logic                  low;
  } irq_cfg_t;

  function automatic logic [DW-1:0] cfg_mask(input int idx);
    case (idx)
      IX_BR_IRQ, IX_SER_IRQ: return DW'((1 << (IRQ_LINE_W + 2)) - 1);
      IX_BR_CTL:             return DW'(1);
      IX_DMA:                return DW'((1 << (DMA_W + BURST_W)) - 1);
      IX_SER_CTL:            return DW'(7);
      IX_TIMER:              return {DW{1'b1}};
      default:               return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_slave_ctl.sv
module cfg_slave_ctl
  import cfg_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctl_o,
  output logic          srst_o,
  output logic          mode_o,
  output logic          clk_stop_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      if (wr_i) ctl_q <= wdata_i[CTL_W-1:0];
      // clock gating may only change under soft reset
      if (ctl_q[CTL_SRST]) stop_q <= ctl_q[CTL_CLK];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:CTL_W];

  assign ctl_o      = {{(DW-CTL_W){1'b0}}, ctl_q};
  assign srst_o     = ctl_q[CTL_SRST];
  assign mode_o     = ctl_q[CTL_MODE];
  assign clk_stop_o = stop_q;

  a_r9_stop_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_o |=> $stable(clk_stop_o));
  a_r2_ctl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctl_o == ($past(wdata_i) & DW'((1 << CTL_W) - 1)));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_port_pkg::*;
#(
  parameter int N_REG = NUM_CFG,
  parameter int W     = DW,
  parameter int IW    = IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    srst_i,
  input  logic                    mode_i,
  input  logic                    idx_wr_i,
  input  logic                    data_wr_i,
  input  logic [W-1:0]            wdata_i,
  output logic [IW-1:0]           idx_o,
  output logic [N_REG-1:0][W-1:0] bytes_o,
  output logic [W-1:0]            data_rd_o
);
  localparam int SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1;

  logic [IW-1:0]           idx_q;
  logic [N_REG-1:0][W-1:0] byte_q;
  logic                    idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_wr_i) idx_q <= wdata_i[IW-1:0];
  end

  assign idx_ok = idx_q < IW'(N_REG);

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic hit;
    assign hit = data_wr_i && mode_i && (idx_q == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     byte_q[g] <= '0;
      else if (srst_i) byte_q[g] <= '0;
      else if (hit)    byte_q[g] <= wdata_i & cfg_mask(g);
    end

    a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_q[g] & ~cfg_mask(g)) == '0);
  end

  always_comb begin
    data_rd_o = '0;
    if (!mode_i)     data_rd_o = {W{1'b1}};
    else if (idx_ok) data_rd_o = byte_q[idx_q[SEL_W-1:0]];
  end

  assign idx_o   = idx_q;
  assign bytes_o = byte_q;

  a_r3_index_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> idx_o == $past(wdata_i[IW-1:0]));
  a_r5_closed_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !mode_i && !srst_i) |=> $stable(bytes_o));
  a_r6_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !idx_ok && !srst_i && !idx_wr_i) |=> $stable(bytes_o));
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_port_pkg::*;
(
  input  logic [NUM_CFG-1:0][DW-1:0] bytes_i,
  output irq_cfg_t                   br_irq_o,
  output logic                       br_en_o,
  output logic [DMA_W-1:0]           dma_chan_o,
  output logic [BURST_W-1:0]         dma_burst_o,
  output irq_cfg_t                   ser_irq_o,
  output logic                       ser_en_o,
  output logic [BASE_W-1:0]          ser_base_o,
  output logic [DW-1:0]              timer_load_o
);
  localparam int IRQ_W = IRQ_LINE_W + 2;
  logic [1:0] base_sel;

  assign br_irq_o     = irq_cfg_t'(bytes_i[IX_BR_IRQ][IRQ_W-1:0]);
  assign ser_irq_o    = irq_cfg_t'(bytes_i[IX_SER_IRQ][IRQ_W-1:0]);
  assign br_en_o      = bytes_i[IX_BR_CTL][0];
  assign dma_chan_o   = bytes_i[IX_DMA][DMA_W-1:0];
  assign dma_burst_o  = bytes_i[IX_DMA][DMA_W+BURST_W-1:DMA_W];
  assign ser_en_o     = bytes_i[IX_SER_CTL][0];
  assign base_sel     = bytes_i[IX_SER_CTL][2:1];
  assign timer_load_o = bytes_i[IX_TIMER];

  always_comb begin
    case (base_sel)
      2'd0:    ser_base_o = BASE_W'(16'h03F8);
      2'd1:    ser_base_o = BASE_W'(16'h02F8);
      2'd2:    ser_base_o = BASE_W'(16'h03E8);
      default: ser_base_o = BASE_W'(16'h02E8);
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bytes_i[IX_BR_IRQ][DW-1:IRQ_W], bytes_i[IX_SER_IRQ][DW-1:IRQ_W],
                         bytes_i[IX_BR_CTL][DW-1:1], bytes_i[IX_DMA][DW-1:DMA_W+BURST_W],
                         bytes_i[IX_SER_CTL][DW-1:3]};
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  port_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        clk_stop_o,
  output logic        core_rst_o,
  output logic        br_irq_low_o,
  output logic        br_irq_pulse_o,
  output logic [2:0]  br_irq_line_o,
  output logic        br_en_o,
  output logic [2:0]  dma_chan_o,
  output logic [1:0]  dma_burst_o,
  output logic        ser_irq_low_o,
  output logic        ser_irq_pulse_o,
  output logic [2:0]  ser_irq_line_o,
  output logic        ser_en_o,
  output logic [15:0] ser_base_o,
  output logic [7:0]  timer_load_o
);
  port_sel_e                  sel;
  logic [DW-1:0]              ctl, data_rd;
  logic [IDX_W-1:0]           idx;
  logic                       srst, mode;
  logic [NUM_CFG-1:0][DW-1:0] cfg_bytes;
  irq_cfg_t                   br_irq, ser_irq;

  assign sel = port_sel_e'(port_i);

  cfg_slave_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && sel == PORT_CTL),
    .wdata_i    (wdata_i),
    .ctl_o      (ctl),
    .srst_o     (srst),
    .mode_o     (mode),
    .clk_stop_o (clk_stop_o)
  );

  cfg_bank i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .mode_i    (mode),
    .idx_wr_i  (wr_en_i && sel == PORT_IDX),
    .data_wr_i (wr_en_i && sel == PORT_DATA),
    .wdata_i   (wdata_i),
    .idx_o     (idx),
    .bytes_o   (cfg_bytes),
    .data_rd_o (data_rd)
  );

  cfg_decode i_dec (
    .bytes_i      (cfg_bytes),
    .br_irq_o     (br_irq),
    .br_en_o      (br_en_o),
    .dma_chan_o   (dma_chan_o),
    .dma_burst_o  (dma_burst_o),
    .ser_irq_o    (ser_irq),
    .ser_en_o     (ser_en_o),
    .ser_base_o   (ser_base_o),
    .timer_load_o (timer_load_o)
  );

  always_comb begin
    case (sel)
      PORT_CTL:  rdata_o = ctl;
      PORT_IDX:  rdata_o = idx;
      PORT_DATA: rdata_o = data_rd;
      default:   rdata_o = '0;
    endcase
  end

  assign core_rst_o      = srst;
  assign br_irq_low_o    = br_irq.low;
  assign br_irq_pulse_o  = br_irq.pulse;
  assign br_irq_line_o   = br_irq.line;
  assign ser_irq_low_o   = ser_irq.low;
  assign ser_irq_pulse_o = ser_irq.pulse;
  assign ser_irq_line_o  = ser_irq.line;

  a_r8_bank_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> (timer_load_o == '0 && ser_base_o == 16'h03F8 && !br_en_o && !ser_en_o));
  a_r11_base_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_base_o inside {16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8});
  a_r2_reserved_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == PORT_CTL) |-> rdata_o[7:3] == '0);
endmodule

// File: tb/test_cfg_port.sv
`timescale 1ns/1ps
module test_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  port = 2'd3;
  logic [7:0]  wd = 8'h00;
  logic [7:0]  rdata;
  logic        clk_stop, core_rst, bl, bp, be, sl, sp, se;
  logic [2:0]  bline, dch, sline;
  logic [1:0]  dbu;
  logic [15:0] sbase;
  logic [7:0]  tload;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_ctl, m_idx;
  logic [7:0] m_cfg [8];
  logic       m_stop;

  always #2.5 clk = ~clk;

  cfg_port i_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .port_i(port), .wdata_i(wd),
    .rdata_o(rdata), .clk_stop_o(clk_stop), .core_rst_o(core_rst),
    .br_irq_low_o(bl), .br_irq_pulse_o(bp), .br_irq_line_o(bline), .br_en_o(be),
    .dma_chan_o(dch), .dma_burst_o(dbu), .ser_irq_low_o(sl), .ser_irq_pulse_o(sp),
    .ser_irq_line_o(sline), .ser_en_o(se), .ser_base_o(sbase), .timer_load_o(tload)
  );

  function automatic logic [7:0] mask_of(input int i);
    case (i)
      0: return 8'h1F;
      1: return 8'h01;
      2: return 8'h1F;
      3: return 8'h1F;
      4: return 8'h07;
      5: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] p);
    case (p)
      2'd0: return m_ctl;
      2'd1: return m_idx;
      2'd2: begin
        if (!m_ctl[2]) return 8'hFF;
        if (m_idx < 8'd6) return m_cfg[m_idx[2:0]];
        return 8'h00;
      end
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] model_base();
    case (m_cfg[4][2:1])
      2'd0: return 16'h03F8;
      2'd1: return 16'h02F8;
      2'd2: return 16'h03E8;
      default: return 16'h02E8;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(16'(rdata), 16'(model_read(port)), tag, "rdata");
    chk(16'(clk_stop), 16'(m_stop), "R9", "clk_stop");
    chk(16'(core_rst), 16'(m_ctl[1]), "R8", "core_rst");
    chk(16'({bl, bp, bline}), 16'({m_cfg[0][0], m_cfg[0][1], m_cfg[0][4:2]}), "R10", "bridge irq");
    chk(16'({sl, sp, sline}), 16'({m_cfg[3][0], m_cfg[3][1], m_cfg[3][4:2]}), "R10", "serial irq");
    chk(16'({be, se, dch, dbu}), 16'({m_cfg[1][0], m_cfg[4][0], m_cfg[2][2:0], m_cfg[2][4:3]}), "R10", "enables/dma");
    chk(sbase, model_base(), "R11", "serial base");
    chk(16'(tload), 16'(m_cfg[5]), "R10", "timer load");
  endtask

  // one bus cycle: drive after a falling edge, check read before and state after the rising edge
  task automatic op(input logic w, input logic [1:0] p, input logic [7:0] d, input string tag);
    logic [7:0] n_ctl, n_idx;
    logic [7:0] n_cfg [8];
    logic       n_stop;
    we = w; port = p; wd = d;
    #1;
    chk(16'(rdata), 16'(model_read(p)), tag, "rdata before edge");
    n_ctl = m_ctl; n_idx = m_idx; n_stop = m_stop;
    for (int i = 0; i < 8; i++) n_cfg[i] = m_cfg[i];
    if (w) begin
      if (p == 2'd0) n_ctl = d & 8'h07;
      if (p == 2'd1) n_idx = d;
      if (p == 2'd2 && m_ctl[2] && !m_ctl[1] && m_idx < 8'd6)
        n_cfg[m_idx[2:0]] = d & mask_of(int'(m_idx));
    end
    if (m_ctl[1]) begin
      for (int i = 0; i < 8; i++) n_cfg[i] = 8'h00;
      n_stop = m_ctl[0];
    end
    @(posedge clk);
    m_ctl = n_ctl; m_idx = n_idx; m_stop = n_stop;
    for (int i = 0; i < 8; i++) m_cfg[i] = n_cfg[i];
    @(negedge clk);
    check_all(tag);
    we = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] ix, input logic [7:0] d, input string tag);
    logic [7:0] saved;
    saved = m_ctl;
    op(1'b1, 2'd0, saved | 8'h04, tag);
    op(1'b1, 2'd1, ix, tag);
    op(1'b1, 2'd2, d, tag);
    op(1'b0, 2'd2, 8'h00, tag);
    op(1'b1, 2'd0, saved, "R12");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    m_ctl = 8'h00; m_idx = 8'h00; m_stop = 1'b0;
    for (int i = 0; i < 8; i++) m_cfg[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    op(1'b0, 2'd0, 8'h00, "R1");
    op(1'b0, 2'd1, 8'h00, "R1");

    // R5 closed data port
    op(1'b1, 2'd2, 8'hAB, "R5");
    op(1'b0, 2'd2, 8'h00, "R5");
    op(1'b1, 2'd0, 8'h04, "R5");
    op(1'b0, 2'd2, 8'h00, "R5");
    op(1'b1, 2'd0, 8'h00, "R5");

    // R2 control register reserved bits and null port
    op(1'b1, 2'd0, 8'hF8, "R2");
    op(1'b1, 2'd3, 8'h5A, "R2");
    op(1'b0, 2'd3, 8'h00, "R2");

    // R3 index stores full width without mode
    op(1'b1, 2'd1, 8'hC3, "R3");
    op(1'b0, 2'd1, 8'h00, "R3");

    // R4/R7/R10 every index with all ones
    for (int i = 0; i < 6; i++) cfg_write(8'(i), 8'hFF, "R7");
    cfg_write(8'd0, 8'h16, "R10");
    cfg_write(8'd3, 8'h0D, "R10");
    cfg_write(8'd2, 8'h13, "R4");
    cfg_write(8'd5, 8'h81, "R4");
    for (int s = 0; s < 4; s++) cfg_write(8'd4, 8'(s << 1), "R11");

    // R6 unimplemented indices
    cfg_write(8'd6, 8'hFF, "R6");
    cfg_write(8'd255, 8'h3C, "R6");
    op(1'b1, 2'd0, 8'h04, "R6");
    op(1'b0, 2'd2, 8'h00, "R6");
    op(1'b1, 2'd0, 8'h00, "R6");

    // R9 clock control without soft reset has no effect
    op(1'b1, 2'd0, 8'h01, "R9");
    op(1'b0, 2'd0, 8'h00, "R9");
    op(1'b1, 2'd0, 8'h00, "R9");

    // R8 soft reset clears and holds; R9 stop follows under reset
    op(1'b1, 2'd0, 8'h03, "R8");
    op(1'b0, 2'd0, 8'h00, "R8");
    op(1'b1, 2'd0, 8'h07, "R8");
    op(1'b1, 2'd1, 8'h05, "R8");
    op(1'b1, 2'd2, 8'h07, "R8");
    op(1'b0, 2'd2, 8'h00, "R8");
    op(1'b1, 2'd0, 8'h01, "R9");
    op(1'b1, 2'd0, 8'h00, "R9");
    op(1'b0, 2'd0, 8'h00, "R9");
    cfg_write(8'd5, 8'h42, "R8");
    op(1'b1, 2'd0, 8'h02, "R9");
    op(1'b1, 2'd0, 8'h00, "R9");
    op(1'b0, 2'd0, 8'h00, "R9");

    // pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      logic [7:0]  d;
      r = $urandom();
      d = r[23:16];
      if (r[1:0] == 2'd0 && r[8:5] != 4'd0) d = d & 8'hFD;
      if (r[1:0] == 2'd1) d = d & 8'h07;
      op(r[9] | r[10], r[1:0], d, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule